// File: doc/BRIEF.md
# SD/eMMC Host-Side Control Register Bank

This block holds the controller-specific host registers of an SD/eMMC host controller. It sits at the bottom of a 4 KiB register window on a simple word-wide register bus. The master raises `bus_req` with address, write enable, byte enables and write data. It holds them until it sees `bus_ready`. Offsets below 0x200 are served from a local bank of 32-bit words. Offsets at 0x200 and above are passed, rebased to zero, to a standard slot-register block that lives outside this one.

Three host words have write side effects:
- The information word at 0x00 is read-only. Writing bit 0 of it starts a software reset. The reset clears the bank and sends a one-cycle reset pulse to the slot logic.
- The PHY access word at 0x10 has its acknowledge flag built from its two request flags.
- The eMMC control word at 0x18 never keeps its tune-request bit.

The slot interrupt passes through unchanged.

A small state machine orders every access. It has four states:
- **IDLE** waits for a request.
- **HOST_ACK** returns a host-region result.
- **SW_RESET** acknowledges a software-reset write, pulses the slot reset and clears the bank.
- **SLOT_WAIT** forwards an access to the slot block until that block answers.

The transitions are:
- IDLE→SLOT_WAIT on a request at 0x200 or above.
- IDLE→SW_RESET on a full-word write to 0x00 with bit 0 set.
- IDLE→HOST_ACK on any other request.
- HOST_ACK→IDLE and SW_RESET→IDLE unconditionally.
- SLOT_WAIT→IDLE when the slot block raises its ready.

Top module: `sdhost_ctrl_regs`

## Requirements
- R1: After reset, every host word reads 0 except offset 0x00, which reads 0x00010000; `bus_ready`, `slot_req` and `slot_rst` are low.
- R2: A host-region request seen in IDLE gets `bus_ready` high in exactly the next cycle, for one cycle, with read data valid in that cycle.
- R3: A full-word write to a host offset without side effects (anything except 0x00, 0x10, 0x18) stores all 32 bits, and a read returns them.
- R4: Offset 0x00 always reads 0x00010000; writes with bit 0 clear have no effect.
- R5: A full-word write to 0x00 with bit 0 set raises `slot_rst` for exactly one cycle (the acknowledge cycle) and returns every host word to its R1 value on the next edge.
- R6: A full-word write to 0x10 stores the data with bit 26 replaced by (bit 24 OR bit 25 of the written data).
- R7: A full-word write to 0x18 stores the data with bit 15 forced to 0.
- R8: In the host region, a write whose byte enables are not all ones (4'b1111) changes nothing and starts no reset, and such a read returns 0.
- R9: An access at offset 0x200 or above drives `slot_req` with `slot_addr` = offset − 0x200 and forwards the write enable, byte enables and write data. `bus_ready` and `bus_rdata` follow `slot_ready` and `slot_rdata`.
- R10: `irq_out` equals `slot_irq` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Request, held until `bus_ready` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KiB window |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` |
| bus_ready | output | 1 | Access complete |
| slot_req | output | 1 | Request to the slot register block |
| slot_we | output | 1 | Forwarded write enable |
| slot_addr | output | 12 | Offset rebased by −0x200 |
| slot_be | output | 4 | Forwarded byte enables |
| slot_wdata | output | 32 | Forwarded write data |
| slot_rdata | input | 32 | Slot read data |
| slot_ready | input | 1 | Slot access complete |
| slot_rst | output | 1 | One-cycle reset pulse to the slot block |
| slot_irq | input | 1 | Slot interrupt |
| irq_out | output | 1 | Block interrupt |

## Verification
The bench looks for the following faults:
- **PHY acknowledge:** it writes the request-only, acknowledge-only and both-requests patterns to the PHY port. A design that stores the written acknowledge bit, or that ignores one request bit, reads back the wrong bit 26.
- **Tune bit:** an all-ones write to the eMMC word exposes a tune bit that sticks.
- **Software reset:** it is checked by the count of `slot_rst` pulses and by reading words written before the reset. A missing clear, a stretched pulse, or a reset that also fires on a sub-word write shows up there.
- **Slot path:** slot accesses check the rebased address and the passed-through data. An unrebased or off-by-0x200 address gives a wrong read value.
- **Read latency:** the one-cycle latency of host reads is counted, which catches an extra or missing pipeline stage.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOST_ACK,
        ST_SW_RESET,
        ST_SLOT_WAIT
    } acc_state_t;

    // word indices whose behaviour neighbours depend on
    localparam int unsigned INFO_IDX = 0;
    localparam int unsigned PHY_IDX  = 4;
    localparam int unsigned EMMC_IDX = 6;

    // field positions
    localparam int unsigned SWRST_BIT   = 0;
    localparam int unsigned PHY_WR_BIT  = 24;
    localparam int unsigned PHY_RD_BIT  = 25;
    localparam int unsigned PHY_ACK_BIT = 26;
    localparam int unsigned TUNE_BIT    = 15;

    localparam logic [31:0] INFO_RST = 32'h0001_0000;

    // value stored for a full-word write to word i
    function automatic logic [31:0] shape_word(int unsigned i, logic [31:0] d);
        logic [31:0] r;
        r = d;
        if (i == PHY_IDX) begin
            r[PHY_ACK_BIT] = d[PHY_WR_BIT] | d[PHY_RD_BIT];
        end else if (i == EMMC_IDX) begin
            r[TUNE_BIT] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/hreg_ctrl.sv
module hreg_ctrl
    import hreg_pkg::*;
#(
    parameter int unsigned AW        = 12,
    parameter int unsigned BEW       = 4,
    parameter int unsigned SLOT_BASE = 'h200
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [BEW-1:0] be,
    input  logic           swrst_bit,
    input  logic           slot_ready,
    output logic           host_wr_en,
    output logic           host_rd_en,
    output logic           bank_clear,
    output logic           slot_sel,
    output logic           bus_ready,
    output logic           slot_rst
);

    localparam logic [AW-1:0] BASE = AW'(SLOT_BASE);

    acc_state_t state_q, state_d;

    logic in_host, full_word, info_hit, swrst_hit;

    assign in_host   = addr < BASE;
    assign full_word = &be;
    assign info_hit  = addr[AW-1:2] == '0;
    assign swrst_hit = in_host && we && full_word && info_hit && swrst_bit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (!in_host)       state_d = ST_SLOT_WAIT;
                    else if (swrst_hit) state_d = ST_SW_RESET;
                    else                state_d = ST_HOST_ACK;
                end
            end
            ST_HOST_ACK:  state_d = ST_IDLE;
            ST_SW_RESET:  state_d = ST_IDLE;
            ST_SLOT_WAIT: if (slot_ready) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        host_wr_en = 1'b0;
        host_rd_en = 1'b0;
        bank_clear = 1'b0;
        slot_sel   = 1'b0;
        bus_ready  = 1'b0;
        slot_rst   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                host_wr_en = req && in_host && we && full_word && !swrst_hit;
                host_rd_en = req && in_host && !we;
            end
            ST_HOST_ACK: bus_ready = 1'b1;
            ST_SW_RESET: begin
                bus_ready  = 1'b1;
                slot_rst   = 1'b1;
                bank_clear = 1'b1;
            end
            ST_SLOT_WAIT: begin
                slot_sel  = 1'b1;
                bus_ready = slot_ready;
            end
            default: ;
        endcase
    end

    // R5
    slot_rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst |=> !slot_rst);

    // R2
    host_ready_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && !slot_sel) |=> !bus_ready);

    // R2
    host_ready_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en || host_wr_en) |=> (bus_ready && !slot_sel));

endmodule

// File: rtl/hreg_bank.sv
module hreg_bank
    import hreg_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned WORDS = 128,
    localparam int unsigned IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          clear,
    input  logic          be_full,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_q
);

    logic [DW-1:0] word_v [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        if (i == INFO_IDX) begin : g_const
            assign word_v[i] = DW'(INFO_RST);
        end else begin : g_store
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                              q <= '0;
                else if (clear)                          q <= '0;
                else if (wr_en && idx == IW'(i))         q <= DW'(shape_word(i, 32'(wdata)));
            end
            assign word_v[i] = q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= (rd_en && be_full) ? word_v[idx] : '0;
    end

    // R6
    phy_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IW'(PHY_IDX) && !clear) |=>
        (word_v[PHY_IDX][PHY_ACK_BIT] == ($past(wdata[PHY_WR_BIT]) | $past(wdata[PHY_RD_BIT]))));

    // R7
    tune_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IW'(EMMC_IDX)) |=> !word_v[EMMC_IDX][TUNE_BIT]);

    // R5
    bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_v[PHY_IDX] == '0 && word_v[EMMC_IDX] == '0));

    // R4
    info_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && be_full && idx == IW'(INFO_IDX)) |=> rd_q == DW'(INFO_RST));

endmodule

// File: rtl/sdhost_ctrl_regs.sv
module sdhost_ctrl_regs
    import hreg_pkg::*;
#(
    parameter int unsigned AW        = 12,
    parameter int unsigned DW        = 32,
    parameter int unsigned SLOT_BASE = 'h200
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW/8-1:0] bus_be,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_ready,
    output logic            slot_req,
    output logic            slot_we,
    output logic [AW-1:0]   slot_addr,
    output logic [DW/8-1:0] slot_be,
    output logic [DW-1:0]   slot_wdata,
    input  logic [DW-1:0]   slot_rdata,
    input  logic            slot_ready,
    output logic            slot_rst,
    input  logic            slot_irq,
    output logic            irq_out
);

    localparam int unsigned BEW   = DW / 8;
    localparam int unsigned WORDS = SLOT_BASE / (DW / 8);
    localparam int unsigned IW    = $clog2(WORDS);

    logic          host_wr_en, host_rd_en, bank_clear, slot_sel;
    logic [DW-1:0] host_rdata;

    hreg_ctrl #(.AW(AW), .BEW(BEW), .SLOT_BASE(SLOT_BASE)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (bus_req),
        .we         (bus_we),
        .addr       (bus_addr),
        .be         (bus_be),
        .swrst_bit  (bus_wdata[SWRST_BIT]),
        .slot_ready (slot_ready),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .bank_clear (bank_clear),
        .slot_sel   (slot_sel),
        .bus_ready  (bus_ready),
        .slot_rst   (slot_rst)
    );

    hreg_bank #(.DW(DW), .WORDS(WORDS)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .rd_en   (host_rd_en),
        .clear   (bank_clear),
        .be_full (&bus_be),
        .idx     (bus_addr[IW+1:2]),
        .wdata   (bus_wdata),
        .rd_q    (host_rdata)
    );

    assign slot_req   = slot_sel;
    assign slot_we    = bus_we;
    assign slot_addr  = bus_addr - AW'(SLOT_BASE);
    assign slot_be    = bus_be;
    assign slot_wdata = bus_wdata;
    assign bus_rdata  = slot_sel ? slot_rdata : host_rdata;
    assign irq_out    = slot_irq;

    // R9
    slot_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> (bus_addr >= AW'(SLOT_BASE)));

endmodule

// File: tb/sdhost_ctrl_regs_tb.sv
module sdhost_ctrl_regs_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        slot_req, slot_we, slot_rst;
    logic [11:0] slot_addr;
    logic [3:0]  slot_be;
    logic [31:0] slot_wdata;
    logic [31:0] slot_rdata = '0;
    logic        slot_ready = 1'b0;
    logic        slot_irq = 1'b0;
    logic        irq_out;

    int total = 0, bad = 0, rst_pulses = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [11:0] last_slot_addr = '0;
    logic [31:0] last_slot_wdata = '0;

    always #(CLK_P/2) clk = ~clk;

    sdhost_ctrl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .slot_req(slot_req),
        .slot_we(slot_we), .slot_addr(slot_addr), .slot_be(slot_be),
        .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .slot_ready(slot_ready),
        .slot_rst(slot_rst), .slot_irq(slot_irq), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // slot register model: answers two cycles after a request
    initial begin
        int cnt = 0;
        forever begin
            @(posedge clk);
            #1;
            if (slot_ready) begin
                slot_ready = 1'b0;
            end else if (slot_req) begin
                cnt++;
                if (cnt == 2) begin
                    cnt = 0;
                    slot_rdata = 32'hC0DE_0000 | {20'h0, slot_addr};
                    if (slot_we) begin
                        last_slot_addr  = slot_addr;
                        last_slot_wdata = slot_wdata;
                    end
                    slot_ready = 1'b1;
                end
            end
        end
    end

    // monitor: pops expected read data when a read completes
    initial begin
        forever begin
            @(negedge clk);
            if (slot_rst) rst_pulses++;
            if (bus_ready && bus_req && !bus_we) begin
                if (exp_q.size() == 0) chk("scoreboard empty", bus_rdata, 32'hx);
                else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic access(input logic we, input logic [11:0] a, input logic [3:0] be,
                          input logic [31:0] d, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!bus_ready && waits < 50);
        #1;
        bus_req = 1'b0;
        if (a < 12'h200) begin
            @(negedge clk);
            chk("R2 ready drops after one cycle", {31'b0, bus_ready}, 32'd0);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        int w;
        access(1'b1, a, be, d, w);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag,
                      input logic [3:0] be = 4'hF);
        int w;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, be, 32'h0, w);
        if (a < 12'h200) chk("R2 host read latency", w, 32'd1);
    endtask

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready low after reset", {31'b0, bus_ready}, 0);
        chk("R1 slot_req low after reset", {31'b0, slot_req}, 0);
        chk("R1 slot_rst low after reset", {31'b0, slot_rst}, 0);
        rd(12'h000, 32'h0001_0000, "R1 info word");
        rd(12'h010, 32'h0, "R1 phy word");
        rd(12'h018, 32'h0, "R1 emmc word");
        rd(12'h1FC, 32'h0, "R1 top host word");

        wr(12'h004, 32'hDEAD_BEEF);
        wr(12'h1FC, 32'h1234_5678);
        rd(12'h004, 32'hDEAD_BEEF, "R3 plain word 0x04");
        rd(12'h1FC, 32'h1234_5678, "R3 plain word 0x1FC");

        p0 = rst_pulses;
        wr(12'h000, 32'hFFFF_FFFE);
        rd(12'h000, 32'h0001_0000, "R4 info unchanged");
        rd(12'h004, 32'hDEAD_BEEF, "R4 no reset on bit0 clear");
        chk("R4 no slot_rst", rst_pulses - p0, 0);

        wr(12'h010, 32'h0100_0000);
        rd(12'h010, 32'h0500_0000, "R6 write request sets ack");
        wr(12'h010, 32'h0200_0000);
        rd(12'h010, 32'h0600_0000, "R6 read request sets ack");
        wr(12'h010, 32'h0400_0000);
        rd(12'h010, 32'h0000_0000, "R6 ack alone cleared");
        wr(12'h010, 32'h0300_0123);
        rd(12'h010, 32'h0700_0123, "R6 both requests");

        wr(12'h018, 32'hFFFF_FFFF);
        rd(12'h018, 32'hFFFF_7FFF, "R7 tune bit dropped");

        wr(12'h004, 32'h0000_0000, 4'h3);
        rd(12'h004, 32'hDEAD_BEEF, "R8 sub-word write ignored");
        rd(12'h004, 32'h0, "R8 sub-word read zero", 4'h1);
        p0 = rst_pulses;
        wr(12'h000, 32'h0000_0001, 4'h7);
        chk("R8 sub-word reset ignored", rst_pulses - p0, 0);
        rd(12'h018, 32'hFFFF_7FFF, "R8 bank kept");

        wr(12'h204, 32'hA5A5_5A5A);
        chk("R9 slot write addr", {20'h0, last_slot_addr}, 32'h004);
        chk("R9 slot write data", last_slot_wdata, 32'hA5A5_5A5A);
        rd(12'h300, 32'hC0DE_0100, "R9 slot read rebased");
        rd(12'hFFC, 32'hC0DE_0DFC, "R9 slot read top");

        @(negedge clk);
        slot_irq = 1'b1;
        #1 chk("R10 irq high", {31'b0, irq_out}, 1);
        slot_irq = 1'b0;
        #1 chk("R10 irq low", {31'b0, irq_out}, 0);

        p0 = rst_pulses;
        wr(12'h000, 32'h0000_0001);
        chk("R5 one slot_rst pulse", rst_pulses - p0, 1);
        rd(12'h004, 32'h0, "R5 plain word cleared");
        rd(12'h010, 32'h0, "R5 phy word cleared");
        rd(12'h018, 32'h0, "R5 emmc word cleared");
        rd(12'h000, 32'h0001_0000, "R5 info restored");

        repeat (2) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule